// File: doc/BRIEF.md
# Sixteen-Pin GPIO Bank with Pin Interrupts

This block is one bank of sixteen general-purpose pins behind a small 16-bit register interface. Software programs the output data, the drive direction, the alternate-function select and the values the pins should hold in sleep and battery-fault conditions. It can read the synchronised level of every pin at any time. The block keeps these settings in registers and drives them out to the pad ring. It does not drive the pads itself.

Each pin can also raise an interrupt. A pin is set either to edge mode or to level mode. Edge mode fires on a rising or a falling transition. Level mode fires on a high or a low level and fires again on every cycle that level is present. Detected events latch into a status register. A per-pin mask, where a 1 blocks the pin, gates the status onto a single bank request line. Software clears the status by writing zero to it. Several banks of this kind are placed side by side at equal address strides, and each has its own request line.

Top module: `gpio_bank`

## Requirements
- R1: After reset every configuration register reads 0, except the interrupt mask (offset 8), which reads 0xFFFF. The request line `irq_o` is low.
- R2: The eleven configuration registers read back exactly the last value written and drive their output ports. The offsets are: output data 1, direction 2, alternate function 3, sleep mask 4, sleep output 5, battery-fault output 6, sleep config 7, mask 8, trigger kind 9, edge polarity 10, level polarity 11.
- R3: Offset 0 returns the pin levels. A pin change driven in one cycle is visible after the second rising clock edge that follows. Writes to offset 0 have no effect.
- R4: A pin whose trigger-kind bit (offset 9) is 1 is in edge mode. Its edge-polarity bit (offset 10) selects the edge: 1 for rising, 0 for falling. The status bit sets at the third rising clock edge after the pin changes.
- R5: A pin whose trigger-kind bit is 0 is in level mode. Its level-polarity bit (offset 11) selects the active level: 1 for high, 0 for low. The status bit sets on every cycle the level is active, so it sets again right after a clear.
- R6: `irq_o` is high when any pin has both its status bit set and its mask bit (offset 8) at 0. An event on a masked pin is still latched in status.
- R7: Writing 0x0000 to the status register (offset 12) clears every latched bit. An event detected in the same cycle as the clear still sets its bit.
- R8: A write of a nonzero value to the status register changes nothing.
- R9: Offsets 13 to 15 read 0, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register word offset |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr` (combinational) |
| pin_i | input | 16 | Pin input levels (asynchronous) |
| dout_o | output | 16 | Output data register |
| dir_o | output | 16 | Direction register |
| alt_o | output | 16 | Alternate-function register |
| slp_mask_o | output | 16 | Sleep mask register |
| slp_out_o | output | 16 | Sleep output register |
| batt_out_o | output | 16 | Battery-fault output register |
| slp_cfg_o | output | 16 | Sleep configuration register |
| irq_o | output | 1 | Bank interrupt request |

## Verification
A software clear of the status register and a newly detected pin event can land in the same clock cycle, and the event must survive the clear. The bench provokes this with edge mode. It changes a pin, lets exactly two clock edges pass so that the synchronised edge is present, and then issues the zero write. The status read right afterwards must hold only the new edge's bit. In level mode the same race shows up as a held level that is still present after a clear. The bench judges that case by requiring the bit to read as set immediately after the clearing write.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int REG_AW = 4;

  typedef enum logic [REG_AW-1:0] {
    RG_LEVEL     = 4'd0,
    RG_DOUT      = 4'd1,
    RG_DIR       = 4'd2,
    RG_ALT       = 4'd3,
    RG_SLP_MASK  = 4'd4,
    RG_SLP_OUT   = 4'd5,
    RG_BATT_OUT  = 4'd6,
    RG_SLP_CFG   = 4'd7,
    RG_IRQ_MASK  = 4'd8,
    RG_TRIG_KIND = 4'd9,
    RG_EDGE_POL  = 4'd10,
    RG_LVL_POL   = 4'd11,
    RG_IRQ_STAT  = 4'd12
  } reg_sel_e;

  // configuration registers occupy offsets 1 .. NUM_CFG
  localparam int NUM_CFG = 11;
endpackage

// File: rtl/gpio_rst_sync.sv
module gpio_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sn = stage_q[1];
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_sn,
  input  logic [W-1:0] raw_i,
  output logic [W-1:0] cur_o,
  output logic [W-1:0] prev_o
);
  logic [W-1:0] meta_q, cur_q, prev_q;

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      meta_q <= '0;
      cur_q  <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= raw_i;
      cur_q  <= meta_q;
      prev_q <= cur_q;
    end
  end

  assign cur_o  = cur_q;
  assign prev_o = prev_q;
endmodule

// File: rtl/gpio_evt_detect.sv
module gpio_evt_detect #(
  parameter int W = 16
) (
  input  logic [W-1:0] cur_i,
  input  logic [W-1:0] prev_i,
  input  logic [W-1:0] kind_i,     // 1 edge, 0 level
  input  logic [W-1:0] edge_pol_i, // 1 rising, 0 falling
  input  logic [W-1:0] lvl_pol_i,  // 1 high, 0 low
  output logic [W-1:0] evt_o
);
  for (genvar p = 0; p < W; p++) begin : g_pin
    logic rise, fall, edge_hit, lvl_hit;
    always_comb begin
      rise     = cur_i[p] & ~prev_i[p];
      fall     = ~cur_i[p] & prev_i[p];
      edge_hit = edge_pol_i[p] ? rise : fall;
      lvl_hit  = lvl_pol_i[p] ? cur_i[p] : ~cur_i[p];
      evt_o[p] = kind_i[p] ? edge_hit : lvl_hit;
    end
  end
endmodule

// File: rtl/gpio_irq_stat.sv
module gpio_irq_stat #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_sn,
  input  logic [W-1:0] evt_i,
  input  logic         clr_i,
  input  logic [W-1:0] mask_i,
  output logic [W-1:0] stat_o,
  output logic         irq_o
);
  logic [W-1:0] stat_d, stat_q;
  logic         stat_en;

  always_comb begin
    stat_en = clr_i | (|evt_i);
    stat_d  = (clr_i ? '0 : stat_q) | evt_i;
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn)      stat_q <= '0;
    else if (stat_en) stat_q <= stat_d;
  end

  assign stat_o = stat_q;
  assign irq_o  = |(stat_q & ~mask_i);
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_bank_pkg::*;
#(
  parameter int NPIN = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [REG_AW-1:0] bus_addr,
  input  logic [NPIN-1:0]   bus_wdata,
  output logic [NPIN-1:0]   bus_rdata,
  input  logic [NPIN-1:0]   pin_i,
  output logic [NPIN-1:0]   dout_o,
  output logic [NPIN-1:0]   dir_o,
  output logic [NPIN-1:0]   alt_o,
  output logic [NPIN-1:0]   slp_mask_o,
  output logic [NPIN-1:0]   slp_out_o,
  output logic [NPIN-1:0]   batt_out_o,
  output logic [NPIN-1:0]   slp_cfg_o,
  output logic              irq_o
);
  localparam logic [REG_AW-1:0] CFG_LAST = REG_AW'(NUM_CFG);

  logic            rst_sn;
  logic [NPIN-1:0] cfg_q [NUM_CFG];
  logic [NPIN-1:0] pin_cur, pin_prev, evt, stat;
  logic            stat_clr;

  gpio_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_sn(rst_sn));

  // configuration register file, one clock-enabled register per offset
  for (genvar g = 0; g < NUM_CFG; g++) begin : g_cfg
    localparam logic [REG_AW-1:0] OFS = REG_AW'(g + 1);
    localparam logic [NPIN-1:0]   RST = (OFS == RG_IRQ_MASK) ? '1 : '0;
    logic            en;
    logic [NPIN-1:0] d;
    always_comb begin
      en = bus_wr && (bus_addr == OFS);
      d  = bus_wdata;
    end
    always_ff @(posedge clk or negedge rst_sn) begin
      if (!rst_sn)  cfg_q[g] <= RST;
      else if (en)  cfg_q[g] <= d;
    end
  end

  gpio_in_sync #(.W(NPIN)) u_sync (
    .clk(clk), .rst_sn(rst_sn), .raw_i(pin_i),
    .cur_o(pin_cur), .prev_o(pin_prev)
  );

  gpio_evt_detect #(.W(NPIN)) u_det (
    .cur_i(pin_cur), .prev_i(pin_prev),
    .kind_i(cfg_q[RG_TRIG_KIND-1]),
    .edge_pol_i(cfg_q[RG_EDGE_POL-1]),
    .lvl_pol_i(cfg_q[RG_LVL_POL-1]),
    .evt_o(evt)
  );

  assign stat_clr = bus_wr && (bus_addr == RG_IRQ_STAT) && (bus_wdata == '0);

  gpio_irq_stat #(.W(NPIN)) u_stat (
    .clk(clk), .rst_sn(rst_sn), .evt_i(evt), .clr_i(stat_clr),
    .mask_i(cfg_q[RG_IRQ_MASK-1]), .stat_o(stat), .irq_o(irq_o)
  );

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == RG_LEVEL)          bus_rdata = pin_cur;
    else if (bus_addr == RG_IRQ_STAT)  bus_rdata = stat;
    else if (bus_addr <= CFG_LAST)     bus_rdata = cfg_q[bus_addr - 4'd1];
  end

  assign dout_o     = cfg_q[RG_DOUT-1];
  assign dir_o      = cfg_q[RG_DIR-1];
  assign alt_o      = cfg_q[RG_ALT-1];
  assign slp_mask_o = cfg_q[RG_SLP_MASK-1];
  assign slp_out_o  = cfg_q[RG_SLP_OUT-1];
  assign batt_out_o = cfg_q[RG_BATT_OUT-1];
  assign slp_cfg_o  = cfg_q[RG_SLP_CFG-1];
endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk
  import gpio_bank_pkg::*;
#(
  parameter int NPIN = 16
) (
  input logic              clk,
  input logic              rst_sn,
  input logic              bus_wr,
  input logic [REG_AW-1:0] bus_addr,
  input logic [NPIN-1:0]   bus_wdata,
  input logic [NPIN-1:0]   stat,
  input logic [NPIN-1:0]   evt,
  input logic [NPIN-1:0]   mask,
  input logic [NPIN-1:0]   dir_o,
  input logic              irq_o
);
  logic clr_wr, stat_wr;
  assign stat_wr = bus_wr && (bus_addr == RG_IRQ_STAT);
  assign clr_wr  = stat_wr && (bus_wdata == '0);

  // R2: direction register takes the written value
  a_r2_dir_write: assert property (@(posedge clk) disable iff (!rst_sn)
    (bus_wr && bus_addr == RG_DIR) |=> (dir_o == $past(bus_wdata)));

  // R5: every detected event shows in status next cycle
  a_r5_evt_latched: assert property (@(posedge clk) disable iff (!rst_sn)
    (evt != '0) |=> ((stat & $past(evt)) == $past(evt)));

  // R6: fully masked bank never requests
  a_r6_masked_quiet: assert property (@(posedge clk) disable iff (!rst_sn)
    (mask == '1) |-> !irq_o);

  // R7: clear leaves only same-cycle events
  a_r7_clear: assert property (@(posedge clk) disable iff (!rst_sn)
    clr_wr |=> (stat == $past(evt)));

  // R8: without a zero write no status bit falls
  a_r8_no_drop: assert property (@(posedge clk) disable iff (!rst_sn)
    !clr_wr |=> ((stat & $past(stat)) == $past(stat)));
endmodule

bind gpio_bank gpio_bank_chk #(.NPIN(NPIN)) u_chk (
  .clk(clk), .rst_sn(rst_sn), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .stat(stat), .evt(evt),
  .mask(cfg_q[gpio_bank_pkg::RG_IRQ_MASK-1]), .dir_o(dir_o), .irq_o(irq_o)
);

// File: tb/gpio_bank_test.sv
module gpio_bank_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic [15:0] pin_i = '0;
  logic [15:0] dout_o, dir_o, alt_o, slp_mask_o, slp_out_o, batt_out_o, slp_cfg_o;
  logic        irq_o;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;
  logic [15:0] shadow [16];

  always #5 clk = ~clk;

  gpio_bank uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_i(pin_i),
    .dout_o(dout_o), .dir_o(dir_o), .alt_o(alt_o), .slp_mask_o(slp_mask_o),
    .slp_out_o(slp_out_o), .batt_out_o(batt_out_o), .slp_cfg_o(slp_cfg_o),
    .irq_o(irq_o)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic wait_clk(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
  endtask

  // bench-side expectation of the reset value of an offset
  function automatic logic [15:0] reset_val(input int a);
    return (a == 8) ? 16'hFFFF : 16'h0000;
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    bad++; total++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [15:0] v;
    void'($urandom(32'h5EED_1234));
    wait_clk(3);
    @(negedge clk) rst_n = 1'b1;
    wait_clk(4);

    // R1 reset state
    for (int a = 1; a <= 11; a++) begin
      rd(4'(a), v); check("R1 reset value", v, reset_val(a));
      shadow[a] = reset_val(a);
    end
    check("R1 irq low", {15'd0, irq_o}, 16'd0);

    // R2 random read-back
    for (int i = 0; i < 60; i++) begin
      int a = 1 + int'($urandom % 11);
      logic [15:0] d = 16'($urandom);
      wr(4'(a), d); shadow[a] = d;
      rd(4'(a), v); check("R2 readback", v, shadow[a]);
      begin
        int b = 1 + int'($urandom % 11);
        rd(4'(b), v); check("R2 other readback", v, shadow[b]);
      end
    end
    check("R2 dir port", dir_o, shadow[2]);
    check("R2 alt port", alt_o, shadow[3]);
    check("R2 batt port", batt_out_o, shadow[6]);
    for (int a = 1; a <= 11; a++) wr(4'(a), reset_val(a));

    // R3 pin level timing and write ignore
    @(negedge clk) pin_i = 16'h3C5A;
    @(posedge clk);
    rd(4'd0, v); check("R3 not yet after one edge", v, 16'h0000);
    @(posedge clk);
    rd(4'd0, v); check("R3 visible after two edges", v, 16'h3C5A);
    for (int i = 0; i < 5; i++) begin
      logic [15:0] p = 16'($urandom);
      @(negedge clk) pin_i = p;
      wait_clk(3);
      rd(4'd0, v); check("R3 random level", v, p);
    end
    wr(4'd0, 16'hFFFF - pin_i);
    rd(4'd0, v); check("R3 write ignored", v, pin_i);

    // R4 edge mode
    @(negedge clk) pin_i = 16'h0000;
    wait_clk(4);
    wr(4'd9, 16'hFFFF);
    wr(4'd10, 16'h00FF);
    wr(4'd8, 16'h0000);
    wr(4'd12, 16'h0000);
    rd(4'd12, v); check("R7 cleared", v, 16'h0000);
    check("R6 irq low no status", {15'd0, irq_o}, 16'd0);
    @(negedge clk) pin_i = 16'hFFFF;
    @(posedge clk);
    rd(4'd12, v); check("R4 none after edge 1", v, 16'h0000);
    @(posedge clk);
    rd(4'd12, v); check("R4 none after edge 2", v, 16'h0000);
    @(posedge clk);
    rd(4'd12, v); check("R4 rising at edge 3", v, 16'h00FF);
    check("R6 irq high", {15'd0, irq_o}, 16'd1);
    @(negedge clk) pin_i = 16'h0000;
    wait_clk(4);
    rd(4'd12, v); check("R4 falling added", v, 16'hFFFF);

    // R6 masking
    wr(4'd8, 16'hFFFF);
    wr(4'd12, 16'h0000);
    @(negedge clk) pin_i = 16'h0001;
    wait_clk(4);
    rd(4'd12, v); check("R6 masked still latched", v, 16'h0001);
    check("R6 masked irq low", {15'd0, irq_o}, 16'd0);
    wr(4'd8, 16'hFFFE);
    check("R6 unmasked irq high", {15'd0, irq_o}, 16'd1);
    wr(4'd8, 16'hFFFF);
    check("R6 remasked irq low", {15'd0, irq_o}, 16'd0);

    // R7 clear racing a new edge
    wr(4'd12, 16'h0000);
    @(negedge clk) pin_i = 16'h0003;
    @(posedge clk);
    @(posedge clk);
    wr(4'd12, 16'h0000);
    rd(4'd12, v); check("R7 event beats clear", v, 16'h0002);

    // R8 nonzero write ignored
    wr(4'd12, 16'h1234);
    rd(4'd12, v); check("R8 nonzero write ignored", v, 16'h0002);

    // R5 level mode
    wr(4'd11, 16'hFFFF);
    wr(4'd9, 16'h0000);
    wr(4'd12, 16'h0000);
    rd(4'd12, v); check("R5 held level resets bits", v, 16'h0003);
    @(negedge clk) pin_i = 16'h0000;
    wait_clk(4);
    wr(4'd12, 16'h0000);
    wait_clk(2);
    rd(4'd12, v); check("R5 inactive level stays clear", v, 16'h0000);
    wr(4'd11, 16'hFF00);
    @(negedge clk) pin_i = 16'h0F0F;
    wait_clk(4);
    wr(4'd12, 16'h0000);
    rd(4'd12, v); check("R5 mixed polarity", v, 16'h0F00 | 16'h00F0);

    // R9 unused offsets
    wr(4'd13, 16'hA5A5);
    rd(4'd13, v); check("R9 offset 13 zero", v, 16'h0000);
    wr(4'd15, 16'h5A5A);
    rd(4'd15, v); check("R9 offset 15 zero", v, 16'h0000);
    rd(4'd8, v); check("R9 mask untouched", v, 16'hFFFF);

    finish_run();
  end
endmodule